// File: doc/BRIEF.md
# Mixer Frame-Start Sequencer

This block runs the start-of-frame protocol in front of a multi-layer video mixer. Every stream it touches carries packets framed by start and end markers, and the low four bits of each packet's first word give the packet type. Type 0 is an image packet, type 15 is a control packet that carries a width and a height, and types 1 to 14 are user packets. At the start of each frame the block copies the background stream's non-image packets straight to the output. When the background's image header arrives, the block consumes that header and takes a first snapshot of the per-layer mode registers.

It then visits each foreground layer whose snapshotted mode is active, in ascending index order. For each such layer it parses control packets for the layer size and drops them. It forwards user packets unchanged. It consumes the layer's image header and then moves on to the next layer. Once every layer is done, the block waits for a software go bit. It then raises its status bit, takes a second snapshot of the layer positions, and emits a type 0 output header. Finally it sends a one-cycle start pulse to the pixel datapath and stays idle until the datapath reports the end of the frame.

Software writes its registers through a simple register bus. The datapath reads only the internal working copies. A register write therefore changes nothing in the current frame and takes effect at the next snapshot point.

Top module: `frame_ctl_seq`

## Requirements
- R1: While waiting for the background image header, every background word that is not a type 0 packet start is forwarded to the output with its data, start and end markers unchanged. The background is back-pressured by the output ready signal.
- R2: A background word with its start marker set and type 0 is consumed and not forwarded. In that same handshake cycle, the foreground mode registers are copied to `act_mode`.
- R3: Foreground layers are visited in ascending index order. Only a layer whose snapshotted mode is 1 (displayed) or 2 (consumed, hidden) is handshaked. Modes 0 and 3 leave that layer's ready low, and the layer is skipped.
- R4: A foreground packet of type 15 is consumed and not forwarded. The low CW bits of its second word become the layer width in `act_w`, and the low CW bits of its third word become the layer height in `act_h`.
- R5: A foreground packet of type 1 to 14 is forwarded to the output unchanged, word by word, under output back-pressure.
- R6: A foreground word with its start marker set and type 0 is consumed and not forwarded, and it ends that layer's non-image phase.
- R7: After the last layer, no output header is emitted while the go bit is 0, and the status bit stays 0.
- R8: Once go is seen as 1, the status bit becomes 1. In the same cycle, the position registers are copied to `act_x` and `act_y`.
- R9: After the position snapshot, one output word is emitted with data 0, the start marker set and the end marker clear. The cycle after it is accepted, `frame_start` is high for exactly one cycle.
- R10: A `frame_end` pulse after the header clears the status bit and returns the block to waiting for background packets. The go bit is not cleared.
- R11: Register writes made after a snapshot leave `act_mode`, `act_x` and `act_y` unchanged until the next frame's snapshot.
- R12: Register map. Address 0 bit 0 holds go (read/write). Address 1 bit 0 holds status (read only). Address 2+2k bits [1:0] hold the mode of foreground lane k. Address 3+2k holds the position of lane k, with X in bits [CW-1:0] and Y in bits [16+CW-1:16]. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| bg_valid | input | 1 | Background word valid |
| bg_ready | output | 1 | Background word accepted |
| bg_data | input | DW | Background word |
| bg_sop | input | 1 | Background start marker |
| bg_eop | input | 1 | Background end marker |
| fg_valid | input | NUM_FG | Foreground lane valid |
| fg_ready | output | NUM_FG | Foreground lane accepted |
| fg_data | input | NUM_FG*DW | Foreground lane words |
| fg_sop | input | NUM_FG | Foreground start markers |
| fg_eop | input | NUM_FG | Foreground end markers |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | DW | Output word |
| out_sop | output | 1 | Output start marker |
| out_eop | output | 1 | Output end marker |
| frame_start | output | 1 | One-cycle start pulse to the datapath |
| frame_end | input | 1 | Datapath end-of-frame pulse |
| act_mode | output | 2*NUM_FG | Snapshotted lane modes |
| act_x | output | NUM_FG*CW | Snapshotted X positions |
| act_y | output | NUM_FG*CW | Snapshotted Y positions |
| act_w | output | NUM_FG*CW | Parsed layer widths |
| act_h | output | NUM_FG*CW | Parsed layer heights |

## Verification
The bench builds the block with NUM_FG=3, DW=16 and CW=12. Three lanes allow a disabled lane to sit between two active ones. They also let the last lane be either active or skipped, so both ways of leaving the foreground walk are exercised. A 16-bit word leaves the upper four bits of each coordinate field unused in the position register, and CW=12 confines each coordinate to the low field bits. Over three frames the bench covers a mode 3 lane, go already set on arrival, and go held low.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [2:0] {ST_BG, ST_FG, ST_GO, ST_HDR, ST_RUN} seq_st_e;
    typedef enum logic [1:0] {PK_IDLE, PK_USER, PK_CTRL} pk_e;

    localparam logic [3:0] TYPE_IMG  = 4'd0;
    localparam logic [3:0] TYPE_CTRL = 4'd15;
    localparam logic [1:0] MODE_SHOW = 2'd1;
    localparam logic [1:0] MODE_HIDE = 2'd2;

    function automatic logic mode_active(input logic [1:0] m);
        return (m == MODE_SHOW) || (m == MODE_HIDE);
    endfunction
endpackage

// File: rtl/fcs_regbank.sv
module fcs_regbank #(
    parameter int NUM_FG = 3,
    parameter int CW     = 12,
    parameter int AW     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [31:0]          wdata,
    input  logic                 sts_i,
    output logic [31:0]          rdata,
    output logic                 go_o,
    output logic [2*NUM_FG-1:0]  mode_o,
    output logic [NUM_FG*CW-1:0] x_o,
    output logic [NUM_FG*CW-1:0] y_o
);
    typedef struct packed {
        logic                 go;
        logic [2*NUM_FG-1:0]  mode;
        logic [NUM_FG*CW-1:0] x;
        logic [NUM_FG*CW-1:0] y;
    } rb_s;

    rb_s q, d;
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_comb begin
        d     = q;
        rdata = '0;
        if (addr == AW'(0)) begin
            rdata[0] = q.go;
            if (wr) d.go = wdata[0];
        end
        if (addr == AW'(1)) rdata[0] = sts_i;
        for (int k = 0; k < NUM_FG; k++) begin
            if (int'(addr) == 2 + 2 * k) begin
                rdata[1:0] = q.mode[2*k +: 2];
                if (wr) d.mode[2*k +: 2] = wdata[1:0];
            end
            if (int'(addr) == 3 + 2 * k) begin
                rdata[CW-1:0]  = q.x[k*CW +: CW];
                rdata[16 +: CW] = q.y[k*CW +: CW];
                if (wr) begin
                    d.x[k*CW +: CW] = wdata[CW-1:0];
                    d.y[k*CW +: CW] = wdata[16 +: CW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go_o   = q.go;
    assign mode_o = q.mode;
    assign x_o    = q.x;
    assign y_o    = q.y;
endmodule

// File: rtl/fcs_lane_mux.sv
module fcs_lane_mux #(
    parameter int NUM_FG = 3,
    parameter int DW     = 16,
    parameter int IW     = 2
) (
    input  logic [IW-1:0]        sel,
    input  logic [NUM_FG-1:0]    v_i,
    input  logic [NUM_FG*DW-1:0] data_i,
    input  logic [NUM_FG-1:0]    sop_i,
    input  logic [NUM_FG-1:0]    eop_i,
    input  logic                 rdy_i,
    output logic                 v_o,
    output logic [DW-1:0]        data_o,
    output logic                 sop_o,
    output logic                 eop_o,
    output logic [NUM_FG-1:0]    rdy_o
);
    for (genvar k = 0; k < NUM_FG; k++) begin : g_rdy
        assign rdy_o[k] = rdy_i && (sel == IW'(k));
    end

    always_comb begin
        v_o    = 1'b0;
        data_o = '0;
        sop_o  = 1'b0;
        eop_o  = 1'b0;
        for (int k = 0; k < NUM_FG; k++) begin
            if (sel == IW'(k)) begin
                v_o    = v_i[k];
                data_o = data_i[k*DW +: DW];
                sop_o  = sop_i[k];
                eop_o  = eop_i[k];
            end
        end
    end
endmodule

// File: rtl/frame_ctl_seq.sv
module frame_ctl_seq
    import fcs_pkg::*;
#(
    parameter int NUM_FG = 3,
    parameter int DW     = 16,
    parameter int CW     = 12,
    parameter int AW     = $clog2(2 * NUM_FG + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 bg_valid,
    output logic                 bg_ready,
    input  logic [DW-1:0]        bg_data,
    input  logic                 bg_sop,
    input  logic                 bg_eop,
    input  logic [NUM_FG-1:0]    fg_valid,
    output logic [NUM_FG-1:0]    fg_ready,
    input  logic [NUM_FG*DW-1:0] fg_data,
    input  logic [NUM_FG-1:0]    fg_sop,
    input  logic [NUM_FG-1:0]    fg_eop,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DW-1:0]        out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic                 frame_start,
    input  logic                 frame_end,
    output logic [2*NUM_FG-1:0]  act_mode,
    output logic [NUM_FG*CW-1:0] act_x,
    output logic [NUM_FG*CW-1:0] act_y,
    output logic [NUM_FG*CW-1:0] act_w,
    output logic [NUM_FG*CW-1:0] act_h
);
    localparam int IW = (NUM_FG > 1) ? $clog2(NUM_FG) : 1;

    typedef struct packed {
        seq_st_e              st;
        logic [IW-1:0]        lane;
        pk_e                  pk;
        logic [1:0]           widx;
        logic                 sts;
        logic                 start;
        logic [2*NUM_FG-1:0]  mode;
        logic [NUM_FG*CW-1:0] x;
        logic [NUM_FG*CW-1:0] y;
        logic [NUM_FG*CW-1:0] w;
        logic [NUM_FG*CW-1:0] h;
    } seq_s;

    seq_s q, d;

    logic                 go_w, sts_w;
    logic [2*NUM_FG-1:0]  sw_mode;
    logic [NUM_FG*CW-1:0] sw_x, sw_y;
    logic                 ln_v, ln_sop, ln_eop, ln_rdy;
    logic [DW-1:0]        ln_data;
    logic                 adv;

    assign sts_w = q.sts;

    fcs_regbank #(.NUM_FG(NUM_FG), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .sts_i(sts_w), .rdata(reg_rdata), .go_o(go_w), .mode_o(sw_mode),
        .x_o(sw_x), .y_o(sw_y)
    );

    fcs_lane_mux #(.NUM_FG(NUM_FG), .DW(DW), .IW(IW)) u_mux (
        .sel(q.lane), .v_i(fg_valid), .data_i(fg_data), .sop_i(fg_sop), .eop_i(fg_eop),
        .rdy_i(ln_rdy), .v_o(ln_v), .data_o(ln_data), .sop_o(ln_sop), .eop_o(ln_eop),
        .rdy_o(fg_ready)
    );

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        bg_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        ln_rdy    = 1'b0;
        adv       = 1'b0;
        case (q.st)
            ST_BG: begin
                if (bg_valid && bg_sop && bg_data[3:0] == TYPE_IMG) begin
                    bg_ready = 1'b1;
                    d.mode   = sw_mode;
                    d.lane   = '0;
                    d.pk     = PK_IDLE;
                    d.st     = ST_FG;
                end else begin
                    out_valid = bg_valid;
                    out_data  = bg_data;
                    out_sop   = bg_sop;
                    out_eop   = bg_eop;
                    bg_ready  = out_ready;
                end
            end
            ST_FG: begin
                if (!mode_active(q.mode[2*q.lane +: 2])) begin
                    adv = 1'b1;
                end else begin
                    case (q.pk)
                        PK_IDLE: begin
                            if (ln_v && ln_sop && ln_data[3:0] == TYPE_IMG) begin
                                ln_rdy = 1'b1;
                                adv    = 1'b1;
                            end else if (ln_v && ln_sop && ln_data[3:0] == TYPE_CTRL) begin
                                ln_rdy = 1'b1;
                                d.widx = 2'd1;
                                if (!ln_eop) d.pk = PK_CTRL;
                            end else if (ln_v && ln_sop) begin
                                out_valid = 1'b1;
                                out_data  = ln_data;
                                out_sop   = 1'b1;
                                out_eop   = ln_eop;
                                ln_rdy    = out_ready;
                                if (out_ready && !ln_eop) d.pk = PK_USER;
                            end else begin
                                ln_rdy = 1'b1;
                            end
                        end
                        PK_USER: begin
                            out_valid = ln_v;
                            out_data  = ln_data;
                            out_eop   = ln_eop;
                            ln_rdy    = out_ready;
                            if (ln_v && out_ready && ln_eop) d.pk = PK_IDLE;
                        end
                        default: begin
                            ln_rdy = 1'b1;
                            if (ln_v) begin
                                if (q.widx == 2'd1) d.w[q.lane*CW +: CW] = ln_data[CW-1:0];
                                if (q.widx == 2'd2) d.h[q.lane*CW +: CW] = ln_data[CW-1:0];
                                if (q.widx != 2'd3) d.widx = q.widx + 2'd1;
                                if (ln_eop) d.pk = PK_IDLE;
                            end
                        end
                    endcase
                end
                if (adv) begin
                    d.pk = PK_IDLE;
                    if (q.lane == IW'(NUM_FG - 1)) d.st = ST_GO;
                    else d.lane = q.lane + IW'(1);
                end
            end
            ST_GO: begin
                if (go_w) begin
                    d.sts = 1'b1;
                    d.x   = sw_x;
                    d.y   = sw_y;
                    d.st  = ST_HDR;
                end
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
                if (out_ready) begin
                    d.start = 1'b1;
                    d.st    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (frame_end) begin
                    d.sts = 1'b0;
                    d.st  = ST_BG;
                end
            end
            default: d.st = ST_BG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame_start = q.start;
    assign act_mode    = q.mode;
    assign act_x       = q.x;
    assign act_y       = q.y;
    assign act_w       = q.w;
    assign act_h       = q.h;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int NUM_FG = 3,
    parameter int DW     = 16,
    parameter int CW     = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 go,
    input logic                 sts,
    input logic                 bg_valid,
    input logic                 bg_ready,
    input logic [DW-1:0]        bg_data,
    input logic                 bg_sop,
    input logic [NUM_FG-1:0]    fg_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [DW-1:0]        out_data,
    input logic                 out_sop,
    input logic                 frame_start,
    input logic [2*NUM_FG-1:0]  act_mode,
    input logic [NUM_FG*CW-1:0] act_x,
    input logic [NUM_FG*CW-1:0] act_y
);
    assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fg_ready));

    for (genvar k = 0; k < NUM_FG; k++) begin : g_lane
        assert_lane_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fg_ready[k] |-> (act_mode[2*k +: 2] == 2'd1 || act_mode[2*k +: 2] == 2'd2));
    end

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode != $past(act_mode)) |->
            $past(bg_valid && bg_ready && bg_sop && bg_data[3:0] == 4'd0));

    assert_pos_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_x != $past(act_x) || act_y != $past(act_y)) |-> $rose(sts));

    assert_hdr_needs_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && out_data[3:0] == 4'd0) |-> go);

    assert_status_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(go));

    assert_start_after_hdr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(out_valid && out_ready && out_sop && out_data == '0));
endmodule

bind frame_ctl_seq fcs_checker #(.NUM_FG(NUM_FG), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go_w), .sts(sts_w),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_data(bg_data), .bg_sop(bg_sop),
    .fg_ready(fg_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .frame_start(frame_start),
    .act_mode(act_mode), .act_x(act_x), .act_y(act_y)
);

// File: tb/sim_frame_ctl_seq.sv
module sim_frame_ctl_seq;
    localparam int N  = 3;
    localparam int DW = 16;
    localparam int CW = 12;
    localparam int AW = $clog2(2 * N + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          bg_valid = 1'b0, bg_sop = 1'b0, bg_eop = 1'b0, bg_ready;
    logic [DW-1:0] bg_data = '0;
    logic [N-1:0]  fg_valid = '0, fg_sop = '0, fg_eop = '0, fg_ready;
    logic [N*DW-1:0] fg_data = '0;
    logic          out_valid, out_sop, out_eop;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          frame_start;
    logic          frame_end = 1'b0;
    logic [2*N-1:0] act_mode;
    logic [N*CW-1:0] act_x, act_y, act_w, act_h;

    frame_ctl_seq #(.NUM_FG(N), .DW(DW), .CW(CW)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [17:0] olog [0:63];
    int ocnt = 0, start_cnt = 0, took1 = 0, took2 = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && ocnt < 64) begin
                olog[ocnt] <= {out_sop, out_eop, out_data};
                ocnt <= ocnt + 1;
            end
            if (frame_start) start_cnt <= start_cnt + 1;
            if (fg_valid[1] && fg_ready[1]) took1 <= took1 + 1;
            if (fg_valid[2] && fg_ready[2]) took2 <= took2 + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    task automatic push_bg(input logic [DW-1:0] dat, input logic s, input logic e);
        @(negedge clk);
        bg_valid = 1'b1; bg_data = dat; bg_sop = s; bg_eop = e;
        #1;
        while (!bg_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bg_valid = 1'b0; bg_sop = 1'b0; bg_eop = 1'b0;
    endtask

    task automatic push_fg(input int k, input logic [DW-1:0] dat, input logic s, input logic e);
        @(negedge clk);
        fg_valid[k] = 1'b1; fg_data[k*DW +: DW] = dat; fg_sop[k] = s; fg_eop[k] = e;
        #1;
        while (!fg_ready[k]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        fg_valid[k] = 1'b0; fg_sop[k] = 1'b0; fg_eop[k] = 1'b0;
    endtask

    task automatic wait_start(input int n);
        while (start_cnt < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R9 reset out_valid", out_valid, 0);
        chk("R9 reset frame_start", frame_start, 0);
        chk("R2 reset act_mode", act_mode, 0);
        reg_read(1, v);
        chk("R12 reset status", v, 0);
    endtask

    task automatic t_frame1();
        logic [31:0] v;
        reg_write(2, 1);
        reg_write(4, 0);
        reg_write(6, 2);
        reg_write(3, {16'd5, 16'd10});
        reg_write(7, {16'd7, 16'd9});
        reg_read(6, v);
        chk("R12 mode readback", v, 2);
        // lane 1 (disabled) presents a user packet the whole time
        @(negedge clk);
        fg_valid[1] = 1'b1; fg_sop[1] = 1'b1; fg_eop[1] = 1'b1; fg_data[DW +: DW] = 16'h0004;
        push_bg(16'h0013, 1, 0);
        push_bg(16'hAAAA, 0, 0);
        push_bg(16'hBBBB, 0, 1);
        chk("R1 bg count", ocnt, 3);
        chk("R1 bg word0", olog[0], {2'b10, 16'h0013});
        chk("R1 bg word1", olog[1], {2'b00, 16'hAAAA});
        chk("R1 bg word2", olog[2], {2'b01, 16'hBBBB});
        push_bg(16'h0000, 1, 0);
        chk("R2 mode snapshot", act_mode, 6'b10_00_01);
        chk("R2 header not forwarded", ocnt, 3);
        push_fg(0, 16'h000F, 1, 0);
        push_fg(0, 16'd40, 0, 0);
        push_fg(0, 16'd30, 0, 1);
        push_fg(0, 16'h0025, 1, 0);
        push_fg(0, 16'h1234, 0, 1);
        push_fg(0, 16'h0000, 1, 0);
        push_fg(2, 16'h000F, 1, 0);
        push_fg(2, 16'd8, 0, 0);
        push_fg(2, 16'd6, 0, 1);
        push_fg(2, 16'h0000, 1, 0);
        repeat (3) @(negedge clk);
        chk("R4 width lane0", act_w[0 +: CW], 40);
        chk("R4 height lane0", act_h[0 +: CW], 30);
        chk("R4 width lane2", act_w[2*CW +: CW], 8);
        chk("R4 height lane2", act_h[2*CW +: CW], 6);
        chk("R4 R6 only user words added", ocnt, 5);
        chk("R5 user word0", olog[3], {2'b10, 16'h0025});
        chk("R5 user word1", olog[4], {2'b01, 16'h1234});
        chk("R3 disabled lane untouched", took1, 0);
        chk("R7 no header before go", out_valid, 0);
        reg_read(1, v);
        chk("R7 status low before go", v, 0);
        reg_write(3, {16'd6, 16'd11});
        reg_write(0, 1);
        wait_start(1);
        reg_read(1, v);
        chk("R8 status high", v, 1);
        chk("R8 x lane0", act_x[0 +: CW], 11);
        chk("R8 y lane0", act_y[0 +: CW], 6);
        chk("R8 x lane2", act_x[2*CW +: CW], 9);
        chk("R8 y lane2", act_y[2*CW +: CW], 7);
        chk("R9 header word", olog[5], {2'b10, 16'h0000});
        repeat (2) @(negedge clk);
        chk("R9 single start pulse", start_cnt, 1);
    endtask

    task automatic t_midframe();
        logic [31:0] v;
        reg_write(2, 0);
        reg_write(3, {16'd1, 16'd2});
        chk("R11 mode held", act_mode, 6'b10_00_01);
        chk("R11 x held", act_x[0 +: CW], 11);
        chk("R11 y held", act_y[0 +: CW], 6);
        reg_read(3, v);
        chk("R12 pos readback", v, {16'd1, 16'd2});
        end_frame();
        reg_read(1, v);
        chk("R10 status cleared", v, 0);
        reg_read(0, v);
        chk("R10 go kept", v, 1);
        // frame 2: go already 1
        push_bg(16'h0000, 1, 0);
        chk("R11 new mode at next frame", act_mode, 6'b10_00_00);
        push_fg(2, 16'h000F, 1, 0);
        push_fg(2, 16'd20, 0, 0);
        push_fg(2, 16'd10, 0, 1);
        push_fg(2, 16'h0000, 1, 0);
        wait_start(2);
        chk("R11 new x at next frame", act_x[0 +: CW], 2);
        chk("R11 new y at next frame", act_y[0 +: CW], 1);
        chk("R4 skipped lane width kept", act_w[0 +: CW], 40);
        chk("R4 lane2 width frame2", act_w[2*CW +: CW], 20);
    endtask

    task automatic t_gohold();
        logic [31:0] v;
        int t2;
        reg_write(0, 0);
        reg_write(2, 1);
        reg_write(6, 3);
        end_frame();
        push_bg(16'h0000, 1, 0);
        chk("R2 mode3 snapshot", act_mode, 6'b11_00_01);
        t2 = took2;
        @(negedge clk);
        fg_valid[2] = 1'b1; fg_sop[2] = 1'b1; fg_eop[2] = 1'b1; fg_data[2*DW +: DW] = 16'h0007;
        push_fg(0, 16'h0000, 1, 0);
        repeat (10) @(negedge clk);
        chk("R3 mode3 lane skipped", took2 - t2, 0);
        chk("R7 go low no header", out_valid, 0);
        chk("R7 go low no start", start_cnt, 2);
        reg_read(1, v);
        chk("R7 go low status", v, 0);
        reg_write(0, 1);
        wait_start(3);
        chk("R9 start after go", start_cnt, 3);
        @(negedge clk); fg_valid[2] = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_frame1();
        t_midframe();
        t_gohold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule